// File: doc/BRIEF.md
# Dual-bandwidth adaptive tracking filter

This block smooths a stream of signed ADC codes taken from a rectified-voltage sense path. Every accepted sample goes into two first-order low-pass filters at once. One responds quickly and one responds slowly. When the two filter values differ by more than a programmable gap, the signal is moving and the block reports the fast value. When they agree closely, it reports the quieter slow value. Either filter can be replaced by the raw sample.

An external comparator flag stops tracking. While the flag is high, incoming samples are discarded and the filter states and the reported value stay frozen. A phase output shows whether the block is tracking or holding. The block also decodes the comparator reference select into a millivolt value that the comparator can use.

After reset, both filters start from a programmable 8-bit initial value. The filtered value is normally registered and appears one clock after the sample strobe. An optional mode makes it visible in the strobe cycle itself.

Top module: `dbw_track_filter`

## Requirements
- R1: While `rst_n` is low, `y_o` is loaded with `init_i * 4`, and both filter states are loaded with the same value. After reset, `out_vld_o` and `hold_o` are 0.
- R2: Each filter state `s` is kept in units of 1/64 code. An accepted sample `x` updates it as `s += floor((64*x - s) / 2^k)`, with k = 2 for the fast filter and k = 5 for the slow filter. A filter's value is `floor(s/64)`.
- R3: On an accepted sample, the reported value is the new fast value when |fast − slow| is greater than the threshold, and the new slow value otherwise.
- R4: `thr_sel_i` = 0 sets the threshold to 8 codes, and 1 sets it to 16 codes.
- R5: `byp_slow_i` = 1 loads the slow state with the sample itself, so the slow value equals the raw sample.
- R6: `byp_fast_i` = 1 does the same for the fast filter.
- R7: A sample is accepted only when `sample_vld_i` = 1 and `cmp_i` = 0. While `cmp_i` is high, the states and `y_o` are held. `hold_o` (1 = hold, 0 = track) shows the value `cmp_i` had in the previous cycle.
- R8: With `same_cyc_i` = 0, `y_o` takes the new value in the cycle after the strobe, and `out_vld_o` is high for exactly that one cycle.
- R9: With `same_cyc_i` = 1, `y_o` and `out_vld_o` show the new value combinationally during the strobe cycle. `y_o` keeps that value afterwards.
- R10: `cmp_ref_o` is 500 (mV) when `ref_sel_i` = 0, and 300 when `ref_sel_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | DW | Signed ADC code |
| cmp_i | input | 1 | Comparator flag; high requests hold |
| thr_sel_i | input | 1 | Difference threshold select |
| byp_fast_i | input | 1 | Fast filter bypass |
| byp_slow_i | input | 1 | Slow filter bypass |
| init_i | input | INIT_W | Initial value, 20 mV per LSB |
| same_cyc_i | input | 1 | Same-cycle output mode |
| ref_sel_i | input | 1 | Comparator reference select |
| y_o | output | DW | Filtered value |
| out_vld_o | output | 1 | Filtered value updated |
| hold_o | output | 1 | Phase: 1 hold, 0 track |
| cmp_ref_o | output | REF_W | Decoded comparator reference in mV |

## Verification
The bench uses the default parameters: 12-bit codes, 6 fraction bits, shifts of 2 and 5, and an initial-value shift of 2. With these values, an initial setting of 50 places both filters at code 200. A single step of 50 codes then leaves the filters 11 codes apart, which falls between the two thresholds, so one stimulus separates the 8-code and 16-code selections. Because the fraction width exceeds the slow shift, small steps and negative samples produce distinct sub-code residues that a reference model must match exactly.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
    typedef enum logic {
        PH_TRACK = 1'b0,
        PH_HOLD  = 1'b1
    } phase_e;

    localparam int unsigned THR_NARROW  = 8;
    localparam int unsigned THR_WIDE    = 16;
    localparam int unsigned REF_HIGH_MV = 500;
    localparam int unsigned REF_LOW_MV  = 300;
endpackage

// File: rtl/dbw_lpf_step.sv
module dbw_lpf_step #(
    parameter int DW   = 12,
    parameter int FRAC = 6,
    parameter int K    = 2
) (
    input  logic signed [DW+FRAC-1:0] state_i,
    input  logic signed [DW-1:0]      x_i,
    input  logic                      bypass_i,
    output logic signed [DW+FRAC-1:0] state_o,
    output logic signed [DW-1:0]      val_o
);
    localparam int SW = DW + FRAC;

    logic signed [SW-1:0] x_fp;
    logic signed [SW:0]   diff;
    logic signed [SW:0]   step;
    logic signed [SW:0]   sum;
    logic                 unused_msb;

    always_comb begin
        x_fp    = {x_i, {FRAC{1'b0}}};
        diff    = {x_fp[SW-1], x_fp} - {state_i[SW-1], state_i};
        step    = diff >>> K;
        // result lies between old state and sample, so SW bits suffice
        sum     = {state_i[SW-1], state_i} + step;
        state_o = bypass_i ? x_fp : sum[SW-1:0];
        val_o   = state_o[SW-1:FRAC];
    end

    assign unused_msb = sum[SW];
endmodule

// File: rtl/dbw_pick.sv
module dbw_pick #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0] fast_i,
    input  logic signed [DW-1:0] slow_i,
    input  logic                 thr_sel_i,
    output logic signed [DW-1:0] pick_o
);
    import dbw_pkg::*;

    logic signed [DW:0] gap;
    logic        [DW:0] mag;
    logic        [DW:0] thr;

    always_comb begin
        gap    = {fast_i[DW-1], fast_i} - {slow_i[DW-1], slow_i};
        mag    = gap[DW] ? -gap : gap;
        thr    = thr_sel_i ? (DW+1)'(THR_WIDE) : (DW+1)'(THR_NARROW);
        pick_o = (mag > thr) ? fast_i : slow_i;
    end
endmodule

// File: rtl/dbw_track_filter.sv
module dbw_track_filter #(
    parameter int DW         = 12,
    parameter int FRAC       = 6,
    parameter int K_FAST     = 2,
    parameter int K_SLOW     = 5,
    parameter int INIT_W     = 8,
    parameter int INIT_SHIFT = 2,
    parameter int REF_W      = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_vld_i,
    input  logic signed [DW-1:0] sample_i,
    input  logic                 cmp_i,
    input  logic                 thr_sel_i,
    input  logic                 byp_fast_i,
    input  logic                 byp_slow_i,
    input  logic [INIT_W-1:0]    init_i,
    input  logic                 same_cyc_i,
    input  logic                 ref_sel_i,
    output logic signed [DW-1:0] y_o,
    output logic                 out_vld_o,
    output logic                 hold_o,
    output logic [REF_W-1:0]     cmp_ref_o
);
    import dbw_pkg::*;

    localparam int SW     = DW + FRAC;
    localparam int NF     = 2;
    localparam int PAD_W  = DW - INIT_W - INIT_SHIFT;

    typedef struct packed {
        logic signed [SW-1:0] st_fast;
        logic signed [SW-1:0] st_slow;
        logic signed [DW-1:0] y;
        logic                 vld;
        phase_e               ph;
    } reg_t;

    reg_t q, d;

    logic signed [DW-1:0] init_code;
    logic signed [SW-1:0] init_state;
    logic signed [SW-1:0] st_cur [NF];
    logic signed [SW-1:0] st_nxt [NF];
    logic signed [DW-1:0] val_nxt [NF];
    logic signed [DW-1:0] pick;
    logic                 accept;

    // values observed by the bound checker
    logic signed [DW-1:0] y_held;
    logic signed [DW-1:0] fast_now;
    logic signed [DW-1:0] slow_now;

    assign init_code  = {{PAD_W{1'b0}}, init_i, {INIT_SHIFT{1'b0}}};
    assign init_state = {init_code, {FRAC{1'b0}}};
    assign st_cur[0]  = q.st_fast;
    assign st_cur[1]  = q.st_slow;

    for (genvar i = 0; i < NF; i++) begin : g_lpf
        localparam int KI = (i == 0) ? K_FAST : K_SLOW;
        dbw_lpf_step #(.DW(DW), .FRAC(FRAC), .K(KI)) u_step (
            .state_i  (st_cur[i]),
            .x_i      (sample_i),
            .bypass_i ((i == 0) ? byp_fast_i : byp_slow_i),
            .state_o  (st_nxt[i]),
            .val_o    (val_nxt[i])
        );
    end

    dbw_pick #(.DW(DW)) u_pick (
        .fast_i    (val_nxt[0]),
        .slow_i    (val_nxt[1]),
        .thr_sel_i (thr_sel_i),
        .pick_o    (pick)
    );

    always_comb begin
        accept = rst_n && sample_vld_i && !cmp_i;
        d      = q;
        d.ph   = cmp_i ? PH_HOLD : PH_TRACK;
        d.vld  = accept;
        if (accept) begin
            d.st_fast = st_nxt[0];
            d.st_slow = st_nxt[1];
            d.y       = pick;
        end
        if (!rst_n) begin
            d.st_fast = init_state;
            d.st_slow = init_state;
            d.y       = init_code;
            d.vld     = 1'b0;
            d.ph      = PH_TRACK;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign y_o       = (same_cyc_i && accept) ? pick : q.y;
    assign out_vld_o = same_cyc_i ? accept : q.vld;
    assign hold_o    = (q.ph == PH_HOLD);
    assign cmp_ref_o = ref_sel_i ? REF_W'(REF_LOW_MV) : REF_W'(REF_HIGH_MV);

    assign y_held   = q.y;
    assign fast_now = q.st_fast[SW-1:FRAC];
    assign slow_now = q.st_slow[SW-1:FRAC];
endmodule

// File: rtl/dbw_track_filter_chk.sv
module dbw_track_filter_chk #(
    parameter int DW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_vld_i,
    input logic signed [DW-1:0] sample_i,
    input logic                 cmp_i,
    input logic                 byp_fast_i,
    input logic                 byp_slow_i,
    input logic                 same_cyc_i,
    input logic                 out_vld_o,
    input logic                 hold_o,
    input logic signed [DW-1:0] y_held,
    input logic signed [DW-1:0] fast_now,
    input logic signed [DW-1:0] slow_now
);
    assert_phase_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_i |=> hold_o);

    assert_phase_leave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_i |=> !hold_o);

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_i |=> ($stable(y_held) && $stable(fast_now) && $stable(slow_now)));

    assert_pick_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (y_held == fast_now) || (y_held == slow_now));

    assert_slow_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_slow_i && sample_vld_i && !cmp_i) |=> (slow_now == $past(sample_i)));

    assert_fast_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_fast_i && sample_vld_i && !cmp_i) |=> (fast_now == $past(sample_i)));

    assert_late_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && !cmp_i && !same_cyc_i) |=> (out_vld_o || same_cyc_i));
endmodule

bind dbw_track_filter dbw_track_filter_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld_i (sample_vld_i),
    .sample_i     (sample_i),
    .cmp_i        (cmp_i),
    .byp_fast_i   (byp_fast_i),
    .byp_slow_i   (byp_slow_i),
    .same_cyc_i   (same_cyc_i),
    .out_vld_o    (out_vld_o),
    .hold_o       (hold_o),
    .y_held       (y_held),
    .fast_now     (fast_now),
    .slow_now     (slow_now)
);

// File: tb/tb_dbw_track_filter.sv
`timescale 1ns/1ps
module tb_dbw_track_filter;
    localparam int DW = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_vld_i = 1'b0;
    logic signed [DW-1:0] sample_i = '0;
    logic                 cmp_i = 1'b0;
    logic                 thr_sel_i = 1'b0;
    logic                 byp_fast_i = 1'b0;
    logic                 byp_slow_i = 1'b0;
    logic [7:0]           init_i = 8'd50;
    logic                 same_cyc_i = 1'b0;
    logic                 ref_sel_i = 1'b0;
    logic signed [DW-1:0] y_o;
    logic                 out_vld_o;
    logic                 hold_o;
    logic [8:0]           cmp_ref_o;

    int n_chk = 0;
    int n_bad = 0;
    longint m_fs, m_ss, m_y;

    always #2.5 clk = ~clk;

    dbw_track_filter dut (
        .clk(clk), .rst_n(rst_n), .sample_vld_i(sample_vld_i), .sample_i(sample_i),
        .cmp_i(cmp_i), .thr_sel_i(thr_sel_i), .byp_fast_i(byp_fast_i),
        .byp_slow_i(byp_slow_i), .init_i(init_i), .same_cyc_i(same_cyc_i),
        .ref_sel_i(ref_sel_i), .y_o(y_o), .out_vld_o(out_vld_o), .hold_o(hold_o),
        .cmp_ref_o(cmp_ref_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model of one accepted sample (R2..R6)
    task automatic m_step(input longint x);
        longint fx, fo, so, gap;
        fx   = x * 64;
        m_fs = byp_fast_i ? fx : m_fs + ((fx - m_fs) >>> 2);
        m_ss = byp_slow_i ? fx : m_ss + ((fx - m_ss) >>> 5);
        fo   = m_fs >>> 6;
        so   = m_ss >>> 6;
        gap  = (fo > so) ? fo - so : so - fo;
        m_y  = (gap > (thr_sel_i ? 16 : 8)) ? fo : so;
    endtask

    task automatic t_reset(input logic [7:0] init);
        @(negedge clk);
        init_i = init;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        m_fs = longint'(init) * 256;
        m_ss = m_fs;
        m_y  = longint'(init) * 4;
        check("R1 y after reset", longint'(y_o), m_y);
        check("R1 valid after reset", longint'(out_vld_o), 0);
        check("R1 phase after reset", longint'(hold_o), 0);
    endtask

    // apply one sample and check per R7/R8/R9
    task automatic t_apply(input longint x);
        longint held;
        held = m_y;
        @(negedge clk);
        sample_i     = DW'(x);
        sample_vld_i = 1'b1;
        if (!cmp_i) m_step(x);
        if (same_cyc_i) begin
            #1;
            check("R9 same-cycle y", longint'(y_o), cmp_i ? held : m_y);
            check("R9 same-cycle valid", longint'(out_vld_o), cmp_i ? 0 : 1);
        end
        @(negedge clk);
        sample_vld_i = 1'b0;
        #0.1;
        if (cmp_i) begin
            check("R7 y frozen in hold", longint'(y_o), held);
            check("R7 no valid in hold", longint'(out_vld_o), 0);
        end else begin
            check("R8 y after strobe", longint'(y_o), m_y);
            check("R8 valid pulse", longint'(out_vld_o), same_cyc_i ? 0 : 1);
        end
    endtask

    task automatic test_reset_and_ref;
        t_reset(8'd50);
        ref_sel_i = 1'b0; #0.1;
        check("R10 ref 0", longint'(cmp_ref_o), 500);
        ref_sel_i = 1'b1; #0.1;
        check("R10 ref 1", longint'(cmp_ref_o), 300);
        ref_sel_i = 1'b0;
    endtask

    task automatic test_tracking;
        t_reset(8'd50);
        t_apply(204); t_apply(203); t_apply(199); t_apply(206);   // R2 small steps
        t_apply(900); t_apply(905);                               // R3 large step
        check("R3 fast chosen on step", longint'(y_o) > 500 ? 1 : 0, 1);
        t_apply(-300); t_apply(-310); t_apply(-1);                // R2 negative codes
        @(negedge clk);
        check("R8 valid single cycle", longint'(out_vld_o), 0);
    endtask

    task automatic test_threshold;
        thr_sel_i = 1'b1;
        t_reset(8'd50);
        t_apply(250);
        check("R4 wide threshold picks slow", longint'(y_o), 201);
        thr_sel_i = 1'b0;
        t_reset(8'd50);
        t_apply(250);
        check("R4 narrow threshold picks fast", longint'(y_o), 212);
    endtask

    task automatic test_bypass;
        byp_slow_i = 1'b1;
        t_reset(8'd50);
        t_apply(205);
        check("R5 slow bypass raw sample", longint'(y_o), 205);
        byp_slow_i = 1'b0;
        byp_fast_i = 1'b1;
        t_reset(8'd50);
        t_apply(1000);
        check("R6 fast bypass raw sample", longint'(y_o), 1000);
        byp_fast_i = 1'b0;
        t_apply(1000);
    endtask

    task automatic test_hold;
        t_reset(8'd60);
        t_apply(300);
        @(negedge clk);
        cmp_i = 1'b1;
        @(negedge clk);
        check("R7 phase hold", longint'(hold_o), 1);
        t_apply(-900); t_apply(1500);
        @(negedge clk);
        cmp_i = 1'b0;
        @(negedge clk);
        check("R7 phase track", longint'(hold_o), 0);
        t_apply(310);   // resumes from frozen states
        t_apply(320);
    endtask

    task automatic test_same_cycle;
        same_cyc_i = 1'b1;
        t_reset(8'd40);
        t_apply(170); t_apply(600); t_apply(-50);
        cmp_i = 1'b1;
        t_apply(800);
        cmp_i = 1'b0;
        t_apply(10);
        same_cyc_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset_and_ref();
        test_tracking();
        test_threshold();
        test_bypass();
        test_hold();
        test_same_cycle();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule